// File: doc/BRIEF.md
# Interrupt Request Front End

This block sits between a processor core and its two interrupt pins. The non-maskable pin goes through a two-stage synchronizer. A rising level is accepted only after the synchronized signal has stayed high long enough, and an accepted rise is held in a pending latch until the core takes it. The maskable pin is level-sensitive. It is registered on every rising clock edge and is honoured only while the core's interrupt-enable flag is set.

The core pulses an instruction-boundary strobe whenever it can accept an interrupt. A block-move instruction also pulses the strobe between its element transfers. At such a strobe, and only when the core's hold-off input is low, the block grants at most one request. A pending non-maskable event always wins over the maskable one. The grant appears as a one-cycle pulse together with the 8-bit interrupt type and the byte address of the matching 4-byte entry in the vector table. A non-maskable grant carries the fixed type 2. A maskable grant carries the type byte that the interrupting device presented during acknowledge.

Top module: `irq_front`

## Requirements
- R1: While rst_n is low, take_nmi_o and take_intr_o are 0, int_type_o is 0 and vec_addr_o is 0.
- R2: A non-maskable event is accepted only if nmi_i is sampled high at three or more consecutive rising clock edges. A pulse seen at one or two edges is ignored.
- R3: An accepted non-maskable event stays pending after nmi_i falls, and stays pending through any number of refused boundaries, until it is granted.
- R4: A grant pulse appears only in the cycle after a cycle in which boundary_i is 1 and nmi_block_i is 0. No grant follows a cycle with boundary_i at 0 or nmi_block_i at 1.
- R5: When a non-maskable event is pending and the maskable request is also valid at a boundary, take_nmi_o is the one granted. Both take outputs are single-cycle pulses and are never 1 together.
- R6: A non-maskable grant sets int_type_o to 2 and vec_addr_o to 8.
- R7: intr_i is registered on each rising edge, so a boundary uses the value sampled at the previous edge. A maskable grant requires that registered value to be 1 and ie_flag_i to be 1 in the boundary cycle. With ie_flag_i at 0 the request is ignored and int_type_o keeps its value.
- R8: A maskable grant sets int_type_o to the ack_type_i value of the boundary cycle. On every grant, vec_addr_o equals int_type_o times 4, that is, the type sits in bits 9:2 and bits 1:0 are zero.
- R9: A non-maskable grant clears the pending latch, so a later boundary with no new event yields no second grant. A new qualified pulse that arrives after the grant is latched again and granted again.
- R10: One high period of nmi_i produces exactly one pending event, however long it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable interrupt pin, asynchronous |
| intr_i | input | 1 | Maskable interrupt request, level-sensitive |
| ie_flag_i | input | 1 | Core interrupt-enable flag |
| boundary_i | input | 1 | Core can accept an interrupt this cycle |
| nmi_block_i | input | 1 | Hold-off: no grant while high |
| ack_type_i | input | 8 | Type byte from the interrupting device |
| take_nmi_o | output | 1 | One-cycle non-maskable grant |
| take_intr_o | output | 1 | One-cycle maskable grant |
| int_type_o | output | 8 | Type of the last grant |
| vec_addr_o | output | 10 | Byte address of that type's vector entry |

## Verification
The assertions assume that the core never drives boundary_i for two cycles in a row while a non-maskable event can qualify in between. The single-pulse check also relies on a pending event needing at least one full cycle to become visible after a grant. They further assume that ack_type_i is valid in the boundary cycle and that nmi_i carries no glitches shorter than a clock period. The stimulus changes every input only at falling clock edges and pulses boundary_i for single cycles. It holds ack_type_i steady across each boundary and drives nmi_i with clean pulses whose widths are whole numbers of clock periods.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int TYPE_W = 8;
  localparam logic [TYPE_W-1:0] NMI_TYPE = 8'd2;
  localparam int ENTRY_BYTES = 4;

  typedef enum logic [1:0] {
    GR_NONE = 2'd0,
    GR_NMI  = 2'd1,
    GR_INTR = 2'd2
  } grant_e;
endpackage

// File: rtl/irq_nmi_detect.sv
module irq_nmi_detect #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HIGH    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  input  logic clear_i,
  output logic pend_o
);
  localparam int CW = $clog2(MIN_HIGH + 2);
  localparam logic [CW-1:0] SAT  = CW'(MIN_HIGH + 1);
  localparam logic [CW-1:0] QUAL = CW'(MIN_HIGH);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   pend_q, pend_d;
  logic                   lvl;
  logic                   qualify;

  // synchronizer chain, next state
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_d = nmi_i;
    end else begin : g_many
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], nmi_i};
    end
  endgenerate

  always_comb begin
    lvl = sync_q[SYNC_STAGES-1];
    if (!lvl) begin
      cnt_d = '0;
    end else if (cnt_q == SAT) begin
      cnt_d = cnt_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    // fires once, in the cycle the high width exceeds MIN_HIGH
    qualify = lvl && (cnt_q == QUAL);
    // a new event wins over the clear of the same cycle
    pend_d  = qualify | (pend_q & ~clear_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  AST_QUAL_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    qualify |-> (lvl && $past(lvl))); // R2
  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !qualify) |=> !pend_q); // R9
  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clear_i) |=> pend_q); // R3
  AST_ONE_PER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (qualify && lvl) |=> !qualify); // R10
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int TW = TYPE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pend_i,
  input  logic          intr_i,
  input  logic          ie_i,
  input  logic          boundary_i,
  input  logic          block_i,
  input  logic [TW-1:0] ack_type_i,
  output logic          grant_nmi_o,
  output logic          take_nmi_o,
  output logic          take_intr_o,
  output logic [TW-1:0] type_o
);
  logic          intr_q;
  grant_e        grant;
  logic          open_win;
  logic          tn_q, ti_q;
  logic [TW-1:0] type_q, type_d;

  always_comb begin
    open_win = boundary_i & ~block_i;
    grant    = GR_NONE;
    if (open_win) begin
      if (pend_i) begin
        grant = GR_NMI;
      end else if (intr_q && ie_i) begin
        grant = GR_INTR;
      end
    end
    unique case (grant)
      GR_NMI:  type_d = TW'(NMI_TYPE);
      GR_INTR: type_d = ack_type_i;
      default: type_d = type_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intr_q <= 1'b0;
      tn_q   <= 1'b0;
      ti_q   <= 1'b0;
      type_q <= '0;
    end else begin
      intr_q <= intr_i;
      tn_q   <= (grant == GR_NMI);
      ti_q   <= (grant == GR_INTR);
      type_q <= type_d;
    end
  end

  assign grant_nmi_o = (grant == GR_NMI);
  assign take_nmi_o  = tn_q;
  assign take_intr_o = ti_q;
  assign type_o      = type_q;

  AST_TAKE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tn_q && ti_q)); // R5
  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ti_q |-> !$past(pend_i)); // R5
  AST_INTR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ti_q |-> $past(ie_i)); // R7
endmodule

// File: rtl/irq_vector.sv
module irq_vector #(
  parameter int TW          = 8,
  parameter int ENTRY_BYTES = 4
) (
  input  logic [TW-1:0]                        type_i,
  output logic [TW+$clog2(ENTRY_BYTES)-1:0]    addr_o
);
  localparam int SH = $clog2(ENTRY_BYTES);
  localparam int AW = TW + SH;

  always_comb begin
    addr_o = AW'(type_i) << SH;
  end
endmodule

// File: rtl/irq_front.sv
module irq_front
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HIGH    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nmi_i,
  input  logic       intr_i,
  input  logic       ie_flag_i,
  input  logic       boundary_i,
  input  logic       nmi_block_i,
  input  logic [7:0] ack_type_i,
  output logic       take_nmi_o,
  output logic       take_intr_o,
  output logic [7:0] int_type_o,
  output logic [9:0] vec_addr_o
);
  logic pend;
  logic grant_nmi;

  irq_nmi_detect #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_HIGH   (MIN_HIGH)
  ) u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .nmi_i  (nmi_i),
    .clear_i(grant_nmi),
    .pend_o (pend)
  );

  irq_arbiter #(
    .TW(TYPE_W)
  ) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_i     (pend),
    .intr_i     (intr_i),
    .ie_i       (ie_flag_i),
    .boundary_i (boundary_i),
    .block_i    (nmi_block_i),
    .ack_type_i (ack_type_i),
    .grant_nmi_o(grant_nmi),
    .take_nmi_o (take_nmi_o),
    .take_intr_o(take_intr_o),
    .type_o     (int_type_o)
  );

  irq_vector #(
    .TW         (TYPE_W),
    .ENTRY_BYTES(ENTRY_BYTES)
  ) u_vec (
    .type_i(int_type_o),
    .addr_o(vec_addr_o)
  );

  AST_WINDOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (take_nmi_o || take_intr_o) |-> $past(boundary_i && !nmi_block_i)); // R4
  AST_NMI_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi_o |-> (int_type_o == 8'd2 && vec_addr_o == 10'd8)); // R6
  AST_SINGLE_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi_o |=> !take_nmi_o); // R5
  AST_INTR_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    take_intr_o |-> (int_type_o == $past(ack_type_i))); // R8
endmodule

// File: tb/test_irq_front.sv
module test_irq_front;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       nmi_i, intr_i, ie_flag_i, boundary_i, nmi_block_i;
  logic [7:0] ack_type_i;
  logic       take_nmi_o, take_intr_o;
  logic [7:0] int_type_o;
  logic [9:0] vec_addr_o;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;

  always #(PERIOD/2) clk = ~clk;

  irq_front i_irq_front (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .intr_i(intr_i),
    .ie_flag_i(ie_flag_i), .boundary_i(boundary_i), .nmi_block_i(nmi_block_i),
    .ack_type_i(ack_type_i), .take_nmi_o(take_nmi_o), .take_intr_o(take_intr_o),
    .int_type_o(int_type_o), .vec_addr_o(vec_addr_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_nmi(input int w);
    nmi_i = 1'b1;
    repeat (w) step();
    nmi_i = 1'b0;
    repeat (6) step();
  endtask

  task automatic fire();
    boundary_i = 1'b1;
    step();
    boundary_i = 1'b0;
  endtask

  task automatic expect_nmi(input string req);
    chk(take_nmi_o == 1'b1, req, take_nmi_o, 1);
    chk(take_intr_o == 1'b0, req, take_intr_o, 0);
    chk(int_type_o == 8'd2, "R6", int_type_o, 2);
    chk(vec_addr_o == 10'd8, "R6", vec_addr_o, 8);
  endtask

  task automatic expect_none(input string req);
    chk(take_nmi_o == 1'b0, req, take_nmi_o, 0);
    chk(take_intr_o == 1'b0, req, take_intr_o, 0);
  endtask

  initial begin
    rst_n = 1'b0; nmi_i = 1'b0; intr_i = 1'b0; ie_flag_i = 1'b0;
    boundary_i = 1'b0; nmi_block_i = 1'b0; ack_type_i = 8'h00;
    repeat (3) step();
    // R1 reset state
    expect_none("R1");
    chk(int_type_o == 8'd0, "R1", int_type_o, 0);
    chk(vec_addr_o == 10'd0, "R1", vec_addr_o, 0);
    rst_n = 1'b1;
    repeat (2) step();

    // R2 width sweep; R3 pulse already low at the boundary
    for (int w = 1; w <= 6; w++) begin
      pulse_nmi(w);
      fire();
      if (w > 2) expect_nmi("R2");
      else expect_none("R2");
      step();
      expect_none("R5");
    end

    // R4 no boundary, then blocked boundary; R3 pending survives
    pulse_nmi(3);
    step();
    expect_none("R4");
    nmi_block_i = 1'b1;
    fire();
    expect_none("R4");
    nmi_block_i = 1'b0;
    repeat (3) step();
    fire();
    expect_nmi("R3");

    // R5 priority, R8 maskable type afterwards
    intr_i = 1'b1; ie_flag_i = 1'b1; ack_type_i = 8'h55;
    pulse_nmi(3);
    fire();
    expect_nmi("R5");
    step();
    fire();
    chk(take_intr_o == 1'b1, "R8", take_intr_o, 1);
    chk(take_nmi_o == 1'b0, "R5", take_nmi_o, 0);
    chk(int_type_o == 8'h55, "R8", int_type_o, 8'h55);
    chk(vec_addr_o == 10'h154, "R8", vec_addr_o, 10'h154);

    // R7 mask: ignored, type held
    ie_flag_i = 1'b0; ack_type_i = 8'h11;
    step();
    fire();
    expect_none("R7");
    chk(int_type_o == 8'h55, "R7", int_type_o, 8'h55);

    // R7 sampling delay: intr rises together with the boundary
    ie_flag_i = 1'b1; intr_i = 1'b0;
    step();
    intr_i = 1'b1;
    fire();
    expect_none("R7");
    fire();
    chk(take_intr_o == 1'b1, "R7", take_intr_o, 1);

    // R8 sweep of every type byte
    for (int t = 0; t < 256; t++) begin
      ack_type_i = 8'(t);
      fire();
      chk(take_intr_o == 1'b1, "R8", take_intr_o, 1);
      chk(int_type_o == 8'(t), "R8", int_type_o, t);
      chk(vec_addr_o == 10'(t * 4), "R8", vec_addr_o, t * 4);
      step();
    end
    intr_i = 1'b0;
    step();

    // R9 clear and retrigger
    pulse_nmi(3);
    fire();
    expect_nmi("R9");
    step();
    fire();
    expect_none("R9");
    pulse_nmi(4);
    fire();
    expect_nmi("R9");

    // R10 long high period yields one event
    nmi_i = 1'b1;
    repeat (8) step();
    fire();
    expect_nmi("R10");
    repeat (4) step();
    fire();
    expect_none("R10");
    repeat (10) step();
    fire();
    expect_none("R10");
    nmi_i = 1'b0;
    repeat (6) step();
    fire();
    expect_none("R10");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule